// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block holds a calendar date as packed BCD digits: a four-digit year, a two-digit month, a two-digit day of the month and a weekday index. The time-of-day chain advances it with a one-cycle day-rollover strobe. The block works out leap years and month lengths directly from the BCD digits, with no conversion to binary. It ends each month on its correct last day, carries into the month and then into the year, and steps the weekday on every day advance.

For setting the date, the block has a second operating state. In this state the carry chain is cut and each field has its own increment pulse. A change to the month or the year pulls an out-of-range day back to the last valid day of the new month.

The controller has two states. `ST_RUN` counts days. `ST_SET` takes manual increments. The transition RUN→SET happens at the first clock edge that sees `set_mode` high. The transition SET→RUN happens at the first edge that sees it low. Both transitions take effect for the inputs of the following cycle.

Top module: `bcd_date_counter`

## Requirements
- R1: After an asynchronous active-low reset, the date is year 0x2000, month 0x01, day 0x01 and weekday 5. The weekday is coded 0 = Monday through 6 = Sunday.
- R2: `leap_year` is high when the year is divisible by 4 and not by 100, or when it is divisible by 400. It is decoded from BCD digits: years 2000, 2024, 2400 and 0000 are leap years; years 2023, 2100 and 2401 are not.
- R3: Exactly one month-length flag is high at a time. `len31` is high for months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12. `len30` is high for months 0x04, 0x06, 0x09 and 0x11. `len_feb` is high for 0x02, and that month ends on day 0x29 in a leap year and 0x28 otherwise.
- R4: In `ST_RUN`, a `day_tick` increments the BCD day. On the month's last day, the tick sets the day to 0x01 and increments the month.
- R5: In `ST_RUN`, a tick on day 0x31 of month 0x12 gives month 0x01, day 0x01 and an incremented year. Year 0x9999 wraps to 0x0000.
- R6: In `ST_RUN`, each `day_tick` advances the weekday by one, and weekday 6 wraps to 0.
- R7: The state follows `set_mode` with one register delay. In `ST_SET`, `day_tick` has no effect on any field.
- R8: In `ST_SET`, an increment pulse changes only its own field, with no carry. The day wraps from the month's last day to 0x01. The month wraps from 0x12 to 0x01. The weekday wraps from 6 to 0. Year, month and day pulses leave the weekday unchanged.
- R9: After a manual month or year increment, a day beyond the new month's length becomes that month's last day.
- R10: When several increment pulses are high in the same `ST_SET` cycle, only the highest-priority one acts. The priority order is year, then month, then day, then weekday.
- R11: In `ST_RUN`, the increment pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| day_tick | input | 1 | Day-rollover strobe, one cycle per day |
| set_mode | input | 1 | High selects the manual setting state |
| inc_year | input | 1 | Manual year increment pulse |
| inc_month | input | 1 | Manual month increment pulse |
| inc_day | input | 1 | Manual day increment pulse |
| inc_wday | input | 1 | Manual weekday increment pulse |
| year | output | 16 | Four BCD year digits |
| month | output | 8 | Two BCD month digits |
| day | output | 8 | Two BCD day digits |
| wday | output | 3 | Weekday, 0 = Monday through 6 = Sunday |
| leap_year | output | 1 | Current year is a leap year |
| len31 | output | 1 | Current month has 31 days |
| len30 | output | 1 | Current month has 30 days |
| len_feb | output | 1 | Current month is February |

## Verification
Every date field is registered once, so a tick or increment pulse that is sampled at one rising edge appears on the outputs right after that edge. `set_mode` passes through the state register first, so increment pulses count only from the cycle after `set_mode` is raised. The flags are combinational from the registered date and are valid in the same cycle as the date they describe. The bench drives inputs on the falling edge and checks at the next falling edge, half a cycle after the register updates. It also waits one full cycle after each `set_mode` change before it sends any stimulus.

// File: rtl/bcd_date_pkg.sv
package bcd_date_pkg;

    typedef enum logic [0:0] {
        ST_RUN = 1'b0,
        ST_SET = 1'b1
    } date_mode_e;

    localparam int DIGIT_W = 4;

    // Divisible by 4 from a tens/units digit pair.
    function automatic logic by_four(input logic [3:0] tens, input logic [3:0] units);
        logic even_units_ok;
        logic odd_units_ok;
        even_units_ok = (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
        odd_units_ok  = (units == 4'd2) || (units == 4'd6);
        return tens[0] ? odd_units_ok : even_units_ok;
    endfunction

    // Two-digit BCD increment, 99 wraps to 00.
    function automatic logic [7:0] bcd2_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) begin
            r[3:0] = 4'd0;
            r[7:4] = (v[7:4] == 4'd9) ? 4'd0 : v[7:4] + 4'd1;
        end else begin
            r[3:0] = v[3:0] + 4'd1;
            r[7:4] = v[7:4];
        end
        return r;
    endfunction

    // Last day of a BCD month.
    function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
        logic [7:0] r;
        unique case (m)
            8'h01, 8'h03, 8'h05, 8'h07, 8'h08, 8'h10, 8'h12: r = 8'h31;
            8'h04, 8'h06, 8'h09, 8'h11:                      r = 8'h30;
            default:                                         r = leap ? 8'h29 : 8'h28;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcd_leap_dec.sv
module bcd_leap_dec (
    input  logic [15:0] year_bcd,
    output logic        leap
);
    import bcd_date_pkg::*;

    logic low_zero;
    logic low_div4;
    logic high_div4;

    always_comb begin
        low_zero  = (year_bcd[7:0] == 8'h00);
        low_div4  = by_four(year_bcd[7:4], year_bcd[3:0]);
        high_div4 = by_four(year_bcd[15:12], year_bcd[11:8]);
        leap      = (low_div4 && !low_zero) || (low_zero && high_div4);
    end
endmodule

// File: rtl/bcd_month_dec.sv
module bcd_month_dec (
    input  logic [7:0] month_bcd,
    input  logic       leap,
    output logic       is31,
    output logic       is30,
    output logic       isfeb,
    output logic [7:0] last_day
);
    import bcd_date_pkg::*;

    always_comb begin
        is31     = 1'b0;
        is30     = 1'b0;
        isfeb    = 1'b0;
        unique case (month_bcd)
            8'h01, 8'h03, 8'h05, 8'h07, 8'h08, 8'h10, 8'h12: is31 = 1'b1;
            8'h04, 8'h06, 8'h09, 8'h11:                      is30 = 1'b1;
            default:                                         isfeb = 1'b1;
        endcase
        last_day = month_last(month_bcd, leap);
    end
endmodule

// File: rtl/bcd_year_inc.sv
module bcd_year_inc #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] din,
    output logic [4*DIGITS-1:0] dout
);
    logic [DIGITS-1:0] carry_in;

    assign carry_in[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig;
        assign dig = din[4*g +: 4];
        assign dout[4*g +: 4] = carry_in[g] ? ((dig == 4'd9) ? 4'd0 : dig + 4'd1) : dig;
        if (g < DIGITS - 1) begin : g_chain
            assign carry_in[g+1] = carry_in[g] && (dig == 4'd9);
        end
    end
endmodule

// File: rtl/bcd_date_counter.sv
module bcd_date_counter #(
    parameter logic [15:0] RESET_YEAR  = 16'h2000,
    parameter logic [7:0]  RESET_MONTH = 8'h01,
    parameter logic [7:0]  RESET_DAY   = 8'h01,
    parameter int          WDAYS       = 7,
    parameter int          RESET_WDAY  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        day_tick,
    input  logic        set_mode,
    input  logic        inc_year,
    input  logic        inc_month,
    input  logic        inc_day,
    input  logic        inc_wday,
    output logic [15:0] year,
    output logic [7:0]  month,
    output logic [7:0]  day,
    output logic [2:0]  wday,
    output logic        leap_year,
    output logic        len31,
    output logic        len30,
    output logic        len_feb
);
    import bcd_date_pkg::*;

    localparam int          YEAR_DIGITS = 4;
    localparam logic [2:0]  WD_LAST     = 3'(WDAYS - 1);
    localparam logic [2:0]  WD_RESET    = 3'(RESET_WDAY);

    date_mode_e  state_q;
    logic        set_active;
    logic [15:0] year_q, year_n, year_plus;
    logic [7:0]  month_q, month_n, day_q, day_n;
    logic [2:0]  wday_q, wday_n, wday_plus;
    logic        leap_cur, leap_plus;
    logic [7:0]  last_cur;
    logic [7:0]  month_step;
    logic [7:0]  lim;

    assign set_active = (state_q == ST_SET);

    // Decoders
    bcd_leap_dec u_leap_cur  (.year_bcd(year_q),    .leap(leap_cur));
    bcd_leap_dec u_leap_next (.year_bcd(year_plus), .leap(leap_plus));

    bcd_month_dec u_month_dec (
        .month_bcd (month_q),
        .leap      (leap_cur),
        .is31      (len31),
        .is30      (len30),
        .isfeb     (len_feb),
        .last_day  (last_cur)
    );

    bcd_year_inc #(.DIGITS(YEAR_DIGITS)) u_year_inc (
        .din  (year_q),
        .dout (year_plus)
    );

    assign wday_plus  = (wday_q == WD_LAST) ? 3'd0 : wday_q + 3'd1;
    assign month_step = (month_q == 8'h12) ? 8'h01 : bcd2_inc(month_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= set_mode ? ST_SET : ST_RUN;
        end
    end

    // Next-date logic
    always_comb begin
        year_n  = year_q;
        month_n = month_q;
        day_n   = day_q;
        wday_n  = wday_q;
        lim     = last_cur;
        unique case (state_q)
            ST_RUN: begin
                if (day_tick) begin
                    wday_n = wday_plus;
                    if (day_q == last_cur) begin
                        day_n   = 8'h01;
                        month_n = month_step;
                        if (month_q == 8'h12) begin
                            year_n = year_plus;
                        end
                    end else begin
                        day_n = bcd2_inc(day_q);
                    end
                end
            end
            ST_SET: begin
                if (inc_year) begin
                    year_n = year_plus;
                    lim    = month_last(month_q, leap_plus);
                    day_n  = (day_q > lim) ? lim : day_q;
                end else if (inc_month) begin
                    month_n = month_step;
                    lim     = month_last(month_step, leap_cur);
                    day_n   = (day_q > lim) ? lim : day_q;
                end else if (inc_day) begin
                    day_n = (day_q == last_cur) ? 8'h01 : bcd2_inc(day_q);
                end else if (inc_wday) begin
                    wday_n = wday_plus;
                end
            end
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            year_q  <= RESET_YEAR;
            month_q <= RESET_MONTH;
            day_q   <= RESET_DAY;
            wday_q  <= WD_RESET;
        end else begin
            year_q  <= year_n;
            month_q <= month_n;
            day_q   <= day_n;
            wday_q  <= wday_n;
        end
    end

    assign year      = year_q;
    assign month     = month_q;
    assign day       = day_q;
    assign wday      = wday_q;
    assign leap_year = leap_cur;
endmodule

// File: rtl/bcd_date_counter_chk.sv
module bcd_date_counter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_set,
    input logic        day_tick,
    input logic        inc_year,
    input logic        inc_month,
    input logic        inc_day,
    input logic        inc_wday,
    input logic [15:0] year,
    input logic [7:0]  month,
    input logic [7:0]  day,
    input logic [2:0]  wday,
    input logic        leap_year,
    input logic        len31,
    input logic        len30,
    input logic        len_feb
);
    logic [7:0] allowed;
    logic       any_inc;

    assign allowed = len31 ? 8'h31 : (len30 ? 8'h30 : (leap_year ? 8'h29 : 8'h28));
    assign any_inc = inc_year || inc_month || inc_day || inc_wday;

    assert_flag_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({len31, len30, len_feb}) == 1);

    assert_wday_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wday <= 3'd6);

    assert_wday_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_set && day_tick) |=> (wday == (($past(wday) == 3'd6) ? 3'd0 : $past(wday) + 3'd1)));

    assert_run_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_set && !day_tick) |=> ($stable(year) && $stable(month) && $stable(day) && $stable(wday)));

    assert_set_tick_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_set && !any_inc) |=> ($stable(year) && $stable(month) && $stable(day) && $stable(wday)));

    assert_day_no_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_set && inc_day && !inc_year && !inc_month) |=> ($stable(month) && $stable(year) && $stable(wday)));

    assert_day_in_month_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (day != 8'h00) && (day <= allowed));
endmodule

bind bcd_date_counter bcd_date_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_set    (set_active),
    .day_tick  (day_tick),
    .inc_year  (inc_year),
    .inc_month (inc_month),
    .inc_day   (inc_day),
    .inc_wday  (inc_wday),
    .year      (year),
    .month     (month),
    .day       (day),
    .wday      (wday),
    .leap_year (leap_year),
    .len31     (len31),
    .len30     (len30),
    .len_feb   (len_feb)
);

// File: tb/bcd_date_counter_test.sv
`timescale 1ns/1ps
module bcd_date_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        day_tick = 1'b0, set_mode = 1'b0;
    logic        inc_year = 1'b0, inc_month = 1'b0, inc_day = 1'b0, inc_wday = 1'b0;
    logic [15:0] year;
    logic [7:0]  month, day;
    logic [2:0]  wday;
    logic        leap_year, len31, len30, len_feb;

    int tests = 0;
    int fails = 0;
    int exp_wd = 5;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcd_date_counter uut (
        .clk(clk), .rst_n(rst_n), .day_tick(day_tick), .set_mode(set_mode),
        .inc_year(inc_year), .inc_month(inc_month), .inc_day(inc_day), .inc_wday(inc_wday),
        .year(year), .month(month), .day(day), .wday(wday),
        .leap_year(leap_year), .len31(len31), .len30(len30), .len_feb(len_feb)
    );

    function automatic logic [15:0] bcd4(input int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] bcd2(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic bit is_leap(input int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_date(input string tag, input int y, input int m, input int d);
        chk({tag, " year"},  32'(year),  32'(bcd4(y)));
        chk({tag, " month"}, 32'(month), 32'(bcd2(m)));
        chk({tag, " day"},   32'(day),   32'(bcd2(d)));
        chk({tag, " wday"},  32'(wday),  32'(exp_wd));
    endtask

    task automatic chk_flags(input string tag, input int y, input int m);
        bit f31, f30;
        f31 = (m == 1) || (m == 3) || (m == 5) || (m == 7) || (m == 8) || (m == 10) || (m == 12);
        f30 = (m == 4) || (m == 6) || (m == 9) || (m == 11);
        chk({tag, " R2 leap"}, 32'(leap_year), 32'(is_leap(y)));
        chk({tag, " R3 flags"}, 32'({len31, len30, len_feb}), 32'({f31, f30, (m == 2)}));
    endtask

    task automatic tick();
        @(negedge clk) day_tick = 1'b1;
        @(negedge clk) day_tick = 1'b0;
        exp_wd = (exp_wd + 1) % 7;
    endtask

    task automatic enter_set();
        @(negedge clk) set_mode = 1'b1;
        @(negedge clk);
    endtask

    task automatic leave_set();
        @(negedge clk) set_mode = 1'b0;
        @(negedge clk);
    endtask

    // Runs in ST_SET; one increment per cycle until each field matches.
    task automatic set_date(input int y, input int m, input int d);
        @(negedge clk);
        if (year !== bcd4(y)) begin
            inc_year = 1'b1;
            while (year !== bcd4(y)) @(negedge clk);
            inc_year = 1'b0;
        end
        if (month !== bcd2(m)) begin
            inc_month = 1'b1;
            while (month !== bcd2(m)) @(negedge clk);
            inc_month = 1'b0;
        end
        if (day !== bcd2(d)) begin
            inc_day = 1'b1;
            while (day !== bcd2(d)) @(negedge clk);
            inc_day = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk_date("R1 reset", 2000, 1, 1);
        chk_flags("R1 reset", 2000, 1);
    endtask

    task automatic t_run_ticks();
        tick();
        chk_date("R4 R6 tick", 2000, 1, 2);
        tick();
        chk_date("R6 wrap", 2000, 1, 3);
    endtask

    task automatic t_feb(input int y, input string tag);
        enter_set();
        set_date(y, 2, 28);
        leave_set();
        chk_flags(tag, y, 2);
        tick();
        if (is_leap(y)) begin
            chk_date({tag, " R4 feb29"}, y, 2, 29);
            tick();
        end
        chk_date({tag, " R4 mar1"}, y, 3, 1);
    endtask

    task automatic t_thirty();
        enter_set();
        set_date(2023, 4, 30);
        leave_set();
        chk_flags("R3 apr", 2023, 4);
        tick();
        chk_date("R4 apr30", 2023, 5, 1);
    endtask

    task automatic t_clamp();
        enter_set();
        set_date(2400, 1, 31);
        @(negedge clk) inc_month = 1'b1;
        @(negedge clk) inc_month = 1'b0;
        chk_date("R9 month clamp", 2400, 2, 29);
        inc_year = 1'b1;
        @(negedge clk) inc_year = 1'b0;
        chk_date("R9 year clamp", 2401, 2, 28);
    endtask

    task automatic t_no_carry();
        set_date(2401, 12, 31);
        @(negedge clk) inc_day = 1'b1;
        @(negedge clk) inc_day = 1'b0;
        chk_date("R8 day wrap", 2401, 12, 1);
        set_date(2401, 12, 31);
        @(negedge clk) inc_month = 1'b1;
        @(negedge clk) inc_month = 1'b0;
        chk_date("R8 month wrap", 2401, 1, 31);
    endtask

    task automatic t_priority();
        @(negedge clk) begin inc_year = 1'b1; inc_month = 1'b1; end
        @(negedge clk) begin inc_year = 1'b0; inc_month = 1'b0; end
        chk_date("R10 year wins", 2402, 1, 31);
        inc_day = 1'b1; inc_wday = 1'b1;
        @(negedge clk) begin inc_day = 1'b0; inc_wday = 1'b0; end
        chk_date("R10 day wins", 2402, 1, 1);
    endtask

    task automatic t_wday_set();
        for (int i = 0; i < 7; i++) begin
            inc_wday = 1'b1;
            @(negedge clk) inc_wday = 1'b0;
            exp_wd = (exp_wd + 1) % 7;
            chk("R8 wday step", 32'(wday), 32'(exp_wd));
        end
    endtask

    task automatic t_ignored();
        day_tick = 1'b1;
        @(negedge clk) day_tick = 1'b0;
        chk_date("R7 tick ignored", 2402, 1, 1);
        leave_set();
        inc_year = 1'b1; inc_month = 1'b1; inc_day = 1'b1; inc_wday = 1'b1;
        @(negedge clk) begin inc_year = 1'b0; inc_month = 1'b0; inc_day = 1'b0; inc_wday = 1'b0; end
        chk_date("R11 run incs ignored", 2402, 1, 1);
    endtask

    task automatic t_year_wrap();
        enter_set();
        set_date(9999, 12, 31);
        leave_set();
        chk_flags("R2 9999", 9999, 12);
        tick();
        chk_date("R5 year wrap", 0, 1, 1);
        chk("R2 year 0000 leap", 32'(leap_year), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_ticks();
        t_feb(2000, "y2000");
        t_thirty();
        t_feb(2023, "y2023");
        t_feb(2024, "y2024");
        t_feb(2100, "y2100");
        t_feb(2400, "y2400");
        t_clamp();
        t_no_carry();
        t_priority();
        t_wday_set();
        t_ignored();
        t_year_wrap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog all requirements: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule